// File: doc/BRIEF.md
# Power Rail Enable Sequencer

This block brings up a set of supply rails (by default three: 1.1 V, 1.8 V and 3.3 V) one after another under timer control. It then releases an active-low system reset once every rail has been judged good. A rising power-on request first has to survive a deglitch interval. The block then finishes counting a fixed start delay and raises the first rail enable. It samples that rail's power-good comparator once, at a fixed deadline after the enable, and only then raises the next enable. After the last rail passes, a further hold interval runs before reset is released.

A rail that is not good at its deadline stops the sequence. All enables fall and the block parks in a fault state with a sticky code naming the rail. The only way out is to drop the request and raise it again, which restarts the whole sequence. Dropping the request at any moment drops every enable and reset at once. All delays are counted in milliseconds from a prescaler set by the clock frequency parameter, so simulations can run with a scaled-down clock.

Top module: `pwr_rail_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the state output reads OFF (code 0), all enables are low, the system reset output is low and the fault code is 0.
- R2: A rising request seen in OFF moves the state to DEGLITCH (code 1) for DEGLITCH_MS ms, then to START_WAIT (code 2) for START_MS−DEGLITCH_MS ms. Enable bit 0 rises exactly START_MS ms after the first clock edge that saw the request high.
- R3: A request that goes low before the deglitch interval ends returns the block to OFF with no enable raised.
- R4: Enable bit i (bit 0 = 1.1 V, bit 1 = 1.8 V, bit 2 = 3.3 V) rises exactly CHECK_MS ms after enable bit i−1, and never rises while bit i−1 is low. During enables the state reads RAIL_CHECK (code 3).
- R5: A rail's power-good input is sampled only in the last cycle of its CHECK_MS window. Its value earlier in the window has no effect on the result.
- R6: After the last rail passes, the state reads RESET_HOLD (code 4) for RELEASE_MS ms. Then the state reads RUN (code 5) and the system reset output goes high. The reset output is high only in RUN, with every enable high.
- R7: A rail found not good at its deadline drops all enables in the next cycle. The state then reads FAULT (code 6) and the fault code becomes the rail index plus one (1 = 1.1 V, 2 = 1.8 V, 3 = 3.3 V).
- R8: FAULT is left only for OFF, when the request is low. Restoring the power-good inputs has no effect. The fault code is kept in OFF and is cleared to 0 when the next rising request is accepted.
- R9: A low request in any state moves the state to OFF in the next cycle, with all enables and the reset output low.
- R10: In RUN, power-good inputs are no longer watched: dropping them leaves RUN and the released reset unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, CLK_FREQ_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_req_i | input | 1 | Power-on request, synchronous to clk_i |
| rail_good_i | input | NUM_RAILS | Power-good comparator per rail, bit 0 first in order |
| rail_en_o | output | NUM_RAILS | Rail enables, bit 0 raised first |
| sys_rst_no | output | 1 | Active-low system reset, high only in RUN |
| seq_state_o | output | 3 | Sequencer state code (0 OFF … 6 FAULT) |
| fault_code_o | output | FAULT_W | Sticky failing rail index plus one, 0 = none |

## Verification
The bench drives a behavioural model counting cycles per phase and compares every output on every clock. Stimulus targets a request glitch shorter than the deglitch interval, which a design that starts on the raw edge would follow by raising an enable. It also makes a power-good input good only three cycles before its deadline, and another one good early and bad at the deadline. A design that samples early, or latches the first good value, would pass the bad rail or fail the good one. Further cases are a restart out of FAULT, which a design that clears the code on the falling request would report as 0 in OFF, and a request drop in mid-sequence. A power-good loss in RUN would make a design that keeps monitoring pull reset back low.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [2:0] {
      ST_OFF        = 3'd0,
      ST_DEGLITCH   = 3'd1,
      ST_START_WAIT = 3'd2,
      ST_RAIL_CHECK = 3'd3,
      ST_RESET_HOLD = 3'd4,
      ST_RUN        = 3'd5,
      ST_FAULT      = 3'd6
   } seq_state_t;

   function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/seq_ms_timer.sv
module seq_ms_timer #(
   parameter int unsigned CLK_PER_MS = 1000,
   parameter int unsigned MS_W       = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            restart_i,
   input  logic [MS_W-1:0] limit_ms_i,
   output logic            done_o
);

   localparam int unsigned CYC_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
   localparam logic [MS_W-1:0] MS_SAT = {MS_W{1'b1}};

   logic            tick;
   logic [MS_W-1:0] ms_q;

   generate
      if (CLK_PER_MS < 1) begin : g_bad_rate
         $error("seq_ms_timer: CLK_PER_MS must be at least 1");
      end

      if (CLK_PER_MS == 1) begin : g_no_prescale
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_PER_MS - 1);
         logic [CYC_W-1:0] cyc_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cyc_q <= '0;
            end else if (restart_i || tick) begin
               cyc_q <= '0;
            end else begin
               cyc_q <= cyc_q + 1'b1;
            end
         end

         assign tick = (cyc_q == CYC_LAST);

         p_cyc_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cyc_q <= CYC_LAST);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ms_q <= '0;
      end else if (restart_i) begin
         ms_q <= '0;
      end else if (tick && ms_q != MS_SAT) begin
         ms_q <= ms_q + 1'b1;
      end
   end

   assign done_o = tick && (ms_q == limit_ms_i - 1'b1);

   // R4: a finished window always clears the count on the following edge
   p_done_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && restart_i) |=> (ms_q == '0));

endmodule

// File: rtl/req_edge_detect.sv
module req_edge_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic rise_o
);

   logic prev_q;

   // previous value resets high so a request already high at reset is not a rise
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b1;
      end else begin
         prev_q <= req_i;
      end
   end

   assign rise_o = req_i && !prev_q;

   // R3: a rise is reported only for a request that was low one cycle before
   p_rise_needs_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> !$past(req_i));

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
   import pwrseq_pkg::*;
#(
   parameter int unsigned NUM_RAILS   = 3,
   parameter int unsigned DEGLITCH_MS = 2,
   parameter int unsigned START_MS    = 11,
   parameter int unsigned CHECK_MS    = 10,
   parameter int unsigned RELEASE_MS  = 10,
   parameter int unsigned MS_W        = 4,
   parameter int unsigned RAIL_W      = 2,
   parameter int unsigned FAULT_W     = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_i,
   input  logic               req_rise_i,
   input  logic               done_i,
   input  logic [NUM_RAILS-1:0] rail_good_i,
   output seq_state_t         state_o,
   output logic [RAIL_W-1:0]  rail_idx_o,
   output logic               restart_o,
   output logic [MS_W-1:0]    limit_ms_o,
   output logic [FAULT_W-1:0] fault_code_o
);

   localparam logic [RAIL_W-1:0] LAST_RAIL = RAIL_W'(NUM_RAILS - 1);

   seq_state_t         state_q, state_d;
   logic [RAIL_W-1:0]  rail_q, rail_d;
   logic [FAULT_W-1:0] code_q, code_d;
   logic               advance;
   logic               cur_good;

   assign cur_good = rail_good_i[rail_q];

   always_comb begin
      case (state_q)
         ST_DEGLITCH:   limit_ms_o = MS_W'(DEGLITCH_MS);
         ST_START_WAIT: limit_ms_o = MS_W'(START_MS - DEGLITCH_MS);
         ST_RAIL_CHECK: limit_ms_o = MS_W'(CHECK_MS);
         ST_RESET_HOLD: limit_ms_o = MS_W'(RELEASE_MS);
         default:       limit_ms_o = MS_W'(1);
      endcase
   end

   always_comb begin
      state_d = state_q;
      rail_d  = rail_q;
      code_d  = code_q;
      advance = 1'b0;
      if (!req_i) begin
         state_d = ST_OFF;
      end else begin
         case (state_q)
            ST_OFF: begin
               if (req_rise_i) begin
                  state_d = ST_DEGLITCH;
                  code_d  = '0;
               end
            end
            ST_DEGLITCH: begin
               if (done_i) state_d = ST_START_WAIT;
            end
            ST_START_WAIT: begin
               if (done_i) begin
                  state_d = ST_RAIL_CHECK;
                  rail_d  = '0;
               end
            end
            ST_RAIL_CHECK: begin
               if (done_i) begin
                  if (!cur_good) begin
                     state_d = ST_FAULT;
                     code_d  = FAULT_W'(rail_q) + 1'b1;
                  end else if (rail_q == LAST_RAIL) begin
                     state_d = ST_RESET_HOLD;
                  end else begin
                     rail_d  = rail_q + 1'b1;
                     advance = 1'b1;
                  end
               end
            end
            ST_RESET_HOLD: begin
               if (done_i) state_d = ST_RUN;
            end
            default: ;
         endcase
      end
   end

   assign restart_o = (state_d != state_q) || advance;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_OFF;
         rail_q  <= '0;
         code_q  <= '0;
      end else begin
         state_q <= state_d;
         rail_q  <= rail_d;
         code_q  <= code_d;
      end
   end

   assign state_o      = state_q;
   assign rail_idx_o   = rail_q;
   assign fault_code_o = code_q;

   // R9: a low request always lands in OFF on the next edge
   p_drop_to_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> (state_q == ST_OFF));

   // R7: the parked state always carries a nonzero rail code
   p_fault_has_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FAULT) |-> (code_q != '0));

   // R8: the fault state is left only towards OFF
   p_fault_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FAULT) |=> (state_q == ST_FAULT || state_q == ST_OFF));

   // R10: once running, only a request drop changes the state
   p_run_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RUN && req_i) |=> (state_q == ST_RUN));

   // R2: a new sequence always starts through the deglitch state
   p_start_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_OFF && req_i && req_rise_i) |=> (state_q == ST_DEGLITCH));

endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
   import pwrseq_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ = 250_000_000,
   parameter int unsigned NUM_RAILS   = 3,
   parameter int unsigned DEGLITCH_MS = 2,
   parameter int unsigned START_MS    = 11,
   parameter int unsigned CHECK_MS    = 10,
   parameter int unsigned RELEASE_MS  = 10,
   localparam int unsigned FAULT_W    = $clog2(NUM_RAILS + 1)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 pwr_req_i,
   input  logic [NUM_RAILS-1:0] rail_good_i,
   output logic [NUM_RAILS-1:0] rail_en_o,
   output logic                 sys_rst_no,
   output logic [2:0]           seq_state_o,
   output logic [FAULT_W-1:0]   fault_code_o
);

   localparam int unsigned CLK_PER_MS = CLK_FREQ_HZ / 1000;
   localparam int unsigned MAX_MS     = max_of4(DEGLITCH_MS, START_MS, CHECK_MS, RELEASE_MS);
   localparam int unsigned MS_W       = $clog2(MAX_MS + 1) + 1;
   localparam int unsigned RAIL_W     = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;

   generate
      if (CLK_PER_MS < 1) begin : g_chk_freq
         $error("pwr_rail_seq: CLK_FREQ_HZ must be at least 1000");
      end
      if (NUM_RAILS < 1) begin : g_chk_rails
         $error("pwr_rail_seq: NUM_RAILS must be at least 1");
      end
      if (DEGLITCH_MS < 1 || DEGLITCH_MS >= START_MS) begin : g_chk_deglitch
         $error("pwr_rail_seq: need 1 <= DEGLITCH_MS < START_MS");
      end
      if (CHECK_MS < 1 || RELEASE_MS < 1) begin : g_chk_windows
         $error("pwr_rail_seq: CHECK_MS and RELEASE_MS must be at least 1");
      end
   endgenerate

   seq_state_t         state;
   logic [RAIL_W-1:0]  rail_idx;
   logic               req_rise;
   logic               restart;
   logic               done;
   logic [MS_W-1:0]    limit_ms;

   req_edge_detect i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (pwr_req_i),
      .rise_o (req_rise)
   );

   seq_ms_timer #(
      .CLK_PER_MS (CLK_PER_MS),
      .MS_W       (MS_W)
   ) i_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (restart),
      .limit_ms_i (limit_ms),
      .done_o     (done)
   );

   rail_seq_fsm #(
      .NUM_RAILS   (NUM_RAILS),
      .DEGLITCH_MS (DEGLITCH_MS),
      .START_MS    (START_MS),
      .CHECK_MS    (CHECK_MS),
      .RELEASE_MS  (RELEASE_MS),
      .MS_W        (MS_W),
      .RAIL_W      (RAIL_W),
      .FAULT_W     (FAULT_W)
   ) i_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (pwr_req_i),
      .req_rise_i   (req_rise),
      .done_i       (done),
      .rail_good_i  (rail_good_i),
      .state_o      (state),
      .rail_idx_o   (rail_idx),
      .restart_o    (restart),
      .limit_ms_o   (limit_ms),
      .fault_code_o (fault_code_o)
   );

   logic all_up;
   assign all_up = (state == ST_RESET_HOLD) || (state == ST_RUN);

   generate
      for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
         assign rail_en_o[g] = all_up ||
                               ((state == ST_RAIL_CHECK) && (rail_idx >= RAIL_W'(g)));
         if (g > 0) begin : g_order
            // R4: a rail is never enabled ahead of its predecessor
            p_enable_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
               rail_en_o[g] |-> rail_en_o[g-1]);
         end
      end
   endgenerate

   assign sys_rst_no  = (state == ST_RUN);
   assign seq_state_o = state;

   // R6: reset released only with every rail enabled
   p_release_all_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sys_rst_no |-> (&rail_en_o));

   // R7: a failed check leaves no rail enabled
   p_fault_rails_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_code_o != '0 && state != ST_DEGLITCH && state != ST_START_WAIT &&
       state != ST_RAIL_CHECK) |-> (rail_en_o == '0));

endmodule

// File: tb/test_pwr_rail_seq.sv
module test_pwr_rail_seq;

   localparam int C      = 5;     // cycles per ms at the scaled clock
   localparam int NR     = 3;
   localparam int DEG    = 3;
   localparam int START  = 11;
   localparam int CHK    = 10;
   localparam int REL    = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [NR-1:0] good = '1;
   logic [NR-1:0] en;
   logic          sys_rst_n;
   logic [2:0]    st;
   logic [1:0]    code;

   int n_cmp = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   pwr_rail_seq #(
      .CLK_FREQ_HZ (C * 1000),
      .NUM_RAILS   (NR),
      .DEGLITCH_MS (DEG),
      .START_MS    (START),
      .CHECK_MS    (CHK),
      .RELEASE_MS  (REL)
   ) i_pwr_rail_seq (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .pwr_req_i    (req),
      .rail_good_i  (good),
      .rail_en_o    (en),
      .sys_rst_no   (sys_rst_n),
      .seq_state_o  (st),
      .fault_code_o (code)
   );

   task automatic cmp(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // behavioural reference: phase number, rail index, cycles spent in phase
   int m_st = 0, m_rail = 0, m_cnt = 0, m_code = 0;
   bit m_prev = 1'b1;

   function automatic int phase_ms(input int s);
      case (s)
         1: return DEG;
         2: return START - DEG;
         3: return CHK;
         4: return REL;
         default: return 1000000;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_rail = 0; m_cnt = 0; m_code = 0; m_prev = 1'b1;
      end else begin
         int  nst;
         bit  fresh;
         bit  fin;
         nst   = m_st;
         fresh = 1'b0;
         fin   = (m_cnt == phase_ms(m_st) * C - 1);
         if (!req) nst = 0;
         else begin
            case (m_st)
               0: if (!m_prev) begin nst = 1; m_code = 0; end
               1: if (fin) nst = 2;
               2: if (fin) begin nst = 3; m_rail = 0; end
               3: if (fin) begin
                     if (!good[m_rail]) begin nst = 6; m_code = m_rail + 1; end
                     else if (m_rail == NR - 1) nst = 4;
                     else begin m_rail++; fresh = 1'b1; end
                  end
               4: if (fin) nst = 5;
               default: ;
            endcase
         end
         if (nst != m_st || fresh) m_cnt = 0; else m_cnt++;
         m_st   = nst;
         m_prev = req;
      end
   end

   function automatic int exp_en();
      int v = 0;
      for (int i = 0; i < NR; i++)
         if (m_st == 4 || m_st == 5 || (m_st == 3 && m_rail >= i)) v |= (1 << i);
      return v;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         cmp("R4 enables vs model", en, exp_en());
         cmp("R6 reset output vs model", sys_rst_n, (m_st == 5) ? 1 : 0);
         cmp("R2 state vs model", st, m_st);
         cmp("R7 fault code vs model", code, m_code);
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_state(input int s, input string tag);
      int k = 0;
      while (st != s && k < 2000) begin @(negedge clk); k++; end
      cmp(tag, st, s);
   endtask

   task automatic wait_en(input int b, input string tag);
      int k = 0;
      while (!en[b] && k < 2000) begin @(negedge clk); k++; end
      cmp(tag, en[b], 1);
   endtask

   initial begin
      int k;
      tick(3);
      cmp("R1 state in reset", st, 0);
      cmp("R1 enables in reset", en, 0);
      rst_n = 1'b1;
      tick(1);
      cmp("R1 state after reset", st, 0);
      cmp("R1 enables after reset", en, 0);
      cmp("R1 reset output after reset", sys_rst_n, 0);
      cmp("R1 fault code after reset", code, 0);

      // full good bring-up, timing of first enable
      req = 1'b1;
      k = 0;
      while (!en[0] && k < 2000) begin @(negedge clk); k++; end
      cmp("R2 cycles to first enable", k, START * C + 1);
      k = 0;
      while (!en[1] && k < 2000) begin @(negedge clk); k++; end
      cmp("R4 cycles between enables", k, CHK * C);
      wait_state(5, "R6 reaches RUN");
      cmp("R6 reset released", sys_rst_n, 1);

      // good inputs dropped while running
      good = '0;
      tick(40);
      cmp("R10 still RUN after good loss", st, 5);
      cmp("R10 reset stays released", sys_rst_n, 1);

      req = 1'b0;
      tick(1);
      cmp("R9 OFF after drop", st, 0);
      cmp("R9 enables low after drop", en, 0);
      good = '1;
      tick(4);

      // glitch shorter than deglitch
      req = 1'b1;
      tick(2 * C);
      req = 1'b0;
      tick(2);
      cmp("R3 glitch returns to OFF", st, 0);
      tick(3 * C);
      cmp("R3 no enable from glitch", en, 0);

      // late-good rail 1 passes
      req = 1'b1;
      good[1] = 1'b0;
      wait_en(1, "R4 enable 1 rises");
      tick(CHK * C - 3);
      good[1] = 1'b1;
      wait_en(2, "R5 late good passes");
      wait_state(5, "R5 sequence completes");
      req = 1'b0;
      tick(3);

      // rail 2 fails
      good = 3'b011;
      req = 1'b1;
      wait_state(6, "R7 rail 2 fault state");
      tick(1);
      cmp("R7 fault code rail 2", code, 3);
      cmp("R7 enables dropped", en, 0);
      good = '1;
      tick(60);
      cmp("R8 FAULT held with request high", st, 6);
      req = 1'b0;
      tick(1);
      cmp("R8 OFF after request low", st, 0);
      cmp("R8 code kept in OFF", code, 3);
      req = 1'b1;
      tick(2);
      cmp("R8 code cleared on restart", code, 0);
      cmp("R8 deglitch on restart", st, 1);
      wait_state(5, "R8 restart completes");
      req = 1'b0;
      tick(3);

      // rail 0 good early, bad at deadline
      req = 1'b1;
      wait_en(0, "R4 enable 0 rises");
      tick(CHK * C - 3);
      good[0] = 1'b0;
      wait_state(6, "R5 early good then bad fails");
      tick(1);
      cmp("R5 fault code rail 0", code, 1);
      req = 1'b0;
      good = '1;
      tick(3);

      // drop in mid-sequence
      req = 1'b1;
      wait_en(1, "R9 mid-sequence reached");
      tick(7);
      req = 1'b0;
      tick(1);
      cmp("R9 mid-sequence drop state", st, 0);
      cmp("R9 mid-sequence drop enables", en, 0);
      tick(5);

      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule